// File: doc/BRIEF.md
# Cache Control and Invalidation Unit

This unit holds the control state for a small on-chip data cache and instruction cache. Software writes a control word and an address word through a simple register port. From these it decides, for each data access, whether a miss should allocate a line and whether a hit should update the stored entry. It also keeps the valid bit for every instruction-cache entry. Tag storage, data storage and the bus are outside the unit.

The control word has a freeze bit, a data-enable bit, a write-allocate bit and a burst-enable bit. It also has two command bits that act once and do not stay set. One command drops every instruction-cache valid bit. The other drops a single entry, chosen by the index field of the address word. The instruction side sets valid bits through a fill request. Each fill is tagged as a burst when burst filling is enabled.

Top module: `cache_ctl_unit`

## Requirements
- R1: After reset the control word reads as zero, the address word reads as zero, every instruction-cache valid bit is clear and the burst output is low.
- R2: A control write stores only bit 13 (write-allocate), bit 9 (freeze), bit 8 (data enable) and bit 4 (burst enable); all other bits, including the command bits 3 and 2, read back as zero. The address word stores and returns all 32 bits. `reg_sel` = 0 selects the control word and 1 selects the address word.
- R3: With data enable and freeze both set, a data read or write that misses never asserts `d_alloc`.
- R4: With data enable set, a write hit asserts `d_update` whether or not freeze is set. A read hit asserts neither `d_alloc` nor `d_update`.
- R5: With data enable set and freeze clear, a read miss asserts `d_alloc`. A write miss asserts `d_alloc` only when write-allocate is set.
- R6: With data enable clear, `d_alloc`, `d_update` and `d_hit_out` stay low. With it set, `d_hit_out` follows `d_hit`. Re-enabling makes hits visible again at once, with no refill.
- R7: A control write with bit 3 set clears every instruction-cache valid bit at the clock edge of that write.
- R8: A control write with bit 2 set clears only the entry selected by address-word bits [7:2], at the edge of that write. It does so regardless of the freeze, enable and write-allocate bits written with it.
- R9: An instruction fill sets the valid bit of `i_fill_idx` at the next edge. When a clear hits the same entry at the same edge, the entry ends up invalid.
- R10: `i_burst` is high exactly when `i_fill` is high and burst enable is set.
- R11: `d_alloc`, `d_update` and `d_hit_out` are low whenever `d_req` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = control word, 1 = address word |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| d_req | input | 1 | Data access valid |
| d_write | input | 1 | Data access is a write |
| d_hit | input | 1 | Tag compare result from the data cache |
| d_alloc | output | 1 | Fill or replace the indexed data line |
| d_update | output | 1 | Write the hitting data entry |
| d_hit_out | output | 1 | Hit as reported to the requester |
| i_fill | input | 1 | Instruction-cache fill of one entry |
| i_fill_idx | input | 6 | Entry being filled |
| i_lookup_idx | input | 6 | Entry whose valid bit is reported |
| i_valid | output | 1 | Valid bit of `i_lookup_idx` |
| i_burst | output | 1 | Request burst transfer for this fill |

## Verification
The hardest case to reach is a single-entry clear, or a full clear, that lands on the same edge as a fill of the same entry. The bench first fills the whole instruction cache, one entry per cycle. It then loads an address word whose high bits are noise around the index field. Finally it raises the fill strobe and the command write in the same cycle. It then probes the target entry and its neighbours through the lookup port. The data-side decision matrix runs from a vector table across freeze, enable and write-allocate settings.

// File: rtl/cctl_pkg.sv
package cctl_pkg;

    localparam int REG_W      = 32;
    localparam int BIT_WALLOC = 13;
    localparam int BIT_FREEZE = 9;
    localparam int BIT_DC_ON  = 8;
    localparam int BIT_BURST  = 4;
    localparam int BIT_INV_ALL = 3;
    localparam int BIT_INV_ONE = 2;
    localparam int IDX_LSB    = 2;

    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_ADDR = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic walloc;
        logic freeze;
        logic dc_on;
        logic burst;
    } ctl_fields_t;

    typedef struct packed {
        logic inv_all;
        logic inv_one;
    } ctl_cmd_t;

    typedef struct packed {
        logic alloc;
        logic update;
        logic hit;
    } dresp_t;

    function automatic ctl_fields_t unpack_ctl(input logic [REG_W-1:0] w);
        ctl_fields_t f;
        f.walloc = w[BIT_WALLOC];
        f.freeze = w[BIT_FREEZE];
        f.dc_on  = w[BIT_DC_ON];
        f.burst  = w[BIT_BURST];
        return f;
    endfunction

    function automatic logic [REG_W-1:0] pack_ctl(input ctl_fields_t f);
        logic [REG_W-1:0] w;
        w = '0;
        w[BIT_WALLOC] = f.walloc;
        w[BIT_FREEZE] = f.freeze;
        w[BIT_DC_ON]  = f.dc_on;
        w[BIT_BURST]  = f.burst;
        return w;
    endfunction

endpackage

// File: rtl/cctl_regs.sv
module cctl_regs
    import cctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output ctl_fields_t      ctl_q,
    output logic [REG_W-1:0] addr_q,
    output ctl_cmd_t         cmd
);

    logic ctl_wr;
    logic addr_wr;

    assign ctl_wr  = reg_we && (reg_sel_e'(reg_sel) == SEL_CTRL);
    assign addr_wr = reg_we && (reg_sel_e'(reg_sel) == SEL_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            addr_q <= '0;
        end else begin
            if (ctl_wr)
                ctl_q <= unpack_ctl(reg_wdata);
            if (addr_wr)
                addr_q <= reg_wdata;
        end
    end

    // Command bits act during the write itself and are never stored.
    always_comb begin
        cmd.inv_all = ctl_wr && reg_wdata[BIT_INV_ALL];
        cmd.inv_one = ctl_wr && reg_wdata[BIT_INV_ONE];
    end

    always_comb begin
        if (reg_sel_e'(reg_sel) == SEL_ADDR)
            reg_rdata = addr_q;
        else
            reg_rdata = pack_ctl(ctl_q);
    end

endmodule

// File: rtl/icv_array.sv
module icv_array #(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr_all,
    input  logic               clr_one,
    input  logic [IDX_W-1:0]   clr_idx,
    input  logic               fill,
    input  logic [IDX_W-1:0]   fill_idx,
    input  logic [IDX_W-1:0]   look_idx,
    output logic               valid_o,
    output logic [ENTRIES-1:0] vec_o
);

    logic [ENTRIES-1:0] vld_q;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        logic hit_clr;
        logic hit_fill;
        assign hit_clr  = clr_all || (clr_one && (clr_idx == IDX_W'(e)));
        assign hit_fill = fill && (fill_idx == IDX_W'(e));

        always_ff @(posedge clk) begin
            if (rst)
                vld_q[e] <= 1'b0;
            else if (hit_clr)
                vld_q[e] <= 1'b0;
            else if (hit_fill)
                vld_q[e] <= 1'b1;
        end
    end

    assign valid_o = vld_q[look_idx];
    assign vec_o   = vld_q;

endmodule

// File: rtl/dalloc_dec.sv
module dalloc_dec
    import cctl_pkg::*;
(
    input  ctl_fields_t ctl,
    input  logic        req,
    input  logic        wr,
    input  logic        hit,
    output dresp_t      resp
);

    logic live;

    assign live = req && ctl.dc_on;

    always_comb begin
        resp = '0;
        if (live) begin
            resp.hit = hit;
            if (hit) begin
                resp.update = wr;
            end else if (!ctl.freeze) begin
                resp.alloc = wr ? ctl.walloc : 1'b1;
            end
        end
    end

endmodule

// File: rtl/cache_ctl_unit.sv
module cache_ctl_unit
    import cctl_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             d_req,
    input  logic             d_write,
    input  logic             d_hit,
    output logic             d_alloc,
    output logic             d_update,
    output logic             d_hit_out,
    input  logic             i_fill,
    input  logic [IDX_W-1:0] i_fill_idx,
    input  logic [IDX_W-1:0] i_lookup_idx,
    output logic             i_valid,
    output logic             i_burst
);

    ctl_fields_t        ctl_q;
    logic [REG_W-1:0]   addr_q;
    ctl_cmd_t           cmd;
    dresp_t             dresp;
    logic [ENTRIES-1:0] vld_vec;
    logic [IDX_W-1:0]   inv_idx;

    assign inv_idx = addr_q[IDX_LSB +: IDX_W];

    cctl_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ctl_q     (ctl_q),
        .addr_q    (addr_q),
        .cmd       (cmd)
    );

    icv_array #(.ENTRIES(ENTRIES)) u_icv (
        .clk      (clk),
        .rst      (rst),
        .clr_all  (cmd.inv_all),
        .clr_one  (cmd.inv_one),
        .clr_idx  (inv_idx),
        .fill     (i_fill),
        .fill_idx (i_fill_idx),
        .look_idx (i_lookup_idx),
        .valid_o  (i_valid),
        .vec_o    (vld_vec)
    );

    dalloc_dec u_dec (
        .ctl  (ctl_q),
        .req  (d_req),
        .wr   (d_write),
        .hit  (d_hit),
        .resp (dresp)
    );

    assign d_alloc   = dresp.alloc;
    assign d_update  = dresp.update;
    assign d_hit_out = dresp.hit;
    assign i_burst   = i_fill && ctl_q.burst;

endmodule

// File: rtl/cctl_chk.sv
module cctl_chk #(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input logic               clk,
    input logic               rst,
    input logic               reg_we,
    input logic               reg_sel,
    input logic [31:0]        reg_wdata,
    input logic [31:0]        reg_rdata,
    input logic               d_req,
    input logic               d_write,
    input logic               d_hit,
    input logic               d_alloc,
    input logic               d_update,
    input logic               d_hit_out,
    input logic               freeze,
    input logic               dc_on,
    input logic               i_fill,
    input logic [IDX_W-1:0]   i_fill_idx,
    input logic               i_burst,
    input logic [ENTRIES-1:0] vld_vec
);

    // R3
    frozen_miss_chk: assert property (@(posedge clk) disable iff (rst)
        d_req && dc_on && freeze && !d_hit |-> !d_alloc);

    // R4
    write_hit_upd_chk: assert property (@(posedge clk) disable iff (rst)
        d_req && dc_on && d_hit && d_write |-> d_update);

    // R6
    dc_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !dc_on |-> !d_alloc && !d_update && !d_hit_out);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !d_req |-> !d_alloc && !d_update && !d_hit_out);

    // R2
    cmd_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !reg_sel |-> reg_rdata[3:2] == 2'b00);

    // R7
    inv_all_chk: assert property (@(posedge clk) disable iff (rst)
        reg_we && !reg_sel && reg_wdata[3] |=> vld_vec == '0);

    // R9
    fill_sets_chk: assert property (@(posedge clk) disable iff (rst)
        i_fill && !reg_we |=> vld_vec[$past(i_fill_idx)]);

    // R10
    burst_needs_fill_chk: assert property (@(posedge clk) disable iff (rst)
        i_burst |-> i_fill);

endmodule

bind cache_ctl_unit cctl_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_we     (reg_we),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .d_req      (d_req),
    .d_write    (d_write),
    .d_hit      (d_hit),
    .d_alloc    (d_alloc),
    .d_update   (d_update),
    .d_hit_out  (d_hit_out),
    .freeze     (ctl_q.freeze),
    .dc_on      (ctl_q.dc_on),
    .i_fill     (i_fill),
    .i_fill_idx (i_fill_idx),
    .i_burst    (i_burst),
    .vld_vec    (vld_vec)
);

// File: tb/cache_ctl_unit_tb_top.sv
`timescale 1ns/1ps
module cache_ctl_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_we, reg_sel;
    logic [31:0] reg_wdata, reg_rdata;
    logic        d_req, d_write, d_hit;
    logic        d_alloc, d_update, d_hit_out;
    logic        i_fill;
    logic [5:0]  i_fill_idx, i_lookup_idx;
    logic        i_valid, i_burst;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    cache_ctl_unit dut_i (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .d_req(d_req), .d_write(d_write), .d_hit(d_hit),
        .d_alloc(d_alloc), .d_update(d_update), .d_hit_out(d_hit_out),
        .i_fill(i_fill), .i_fill_idx(i_fill_idx), .i_lookup_idx(i_lookup_idx),
        .i_valid(i_valid), .i_burst(i_burst)
    );

    // {freeze, dc_on, walloc, write, hit, exp_alloc, exp_update, exp_hit}
    localparam logic [7:0] VEC [11] = '{
        8'b01000_100,  // R5 read miss fills
        8'b01001_001,  // R4 read hit: no alloc, no update
        8'b01010_000,  // R5 write miss, no write-allocate
        8'b01110_100,  // R5 write miss with write-allocate
        8'b01011_011,  // R4 write hit updates
        8'b11000_000,  // R3 frozen read miss
        8'b11110_000,  // R3 frozen write miss with write-allocate
        8'b11011_011,  // R4 frozen write hit still updates
        8'b00000_000,  // R6 disabled read miss
        8'b00111_000,  // R6 disabled write hit
        8'b10001_000   // R6 disabled frozen read hit
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr_reg(input logic sel, input logic [31:0] data);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_reg(input logic sel, output logic [31:0] data);
        reg_sel = sel;
        #1;
        data = reg_rdata;
    endtask

    task automatic peek(input int idx, output logic v);
        i_lookup_idx = 6'(idx);
        #0.5;
        v = i_valid;
    endtask

    task automatic fill_all();
        for (int k = 0; k < 64; k++) begin
            @(negedge clk);
            i_fill = 1'b1; i_fill_idx = 6'(k);
        end
        @(negedge clk);
        i_fill = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic        v;
        rst = 1'b1; reg_we = 0; reg_sel = 0; reg_wdata = '0;
        d_req = 0; d_write = 0; d_hit = 0;
        i_fill = 0; i_fill_idx = '0; i_lookup_idx = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_reg(1'b0, r); check("R1 ctrl", r, 32'h0);
        rd_reg(1'b1, r); check("R1 addr", r, 32'h0);
        peek(0, v);  check("R1 valid0", 32'(v), 32'h0);
        peek(63, v); check("R1 valid63", 32'(v), 32'h0);
        check("R1 burst", 32'(i_burst), 32'h0);

        // R2 storage mask and readback
        wr_reg(1'b0, 32'hFFFF_FFFF);
        rd_reg(1'b0, r); check("R2 ctrl mask", r, 32'h0000_2310);
        wr_reg(1'b1, 32'hDEAD_BEEF);
        rd_reg(1'b1, r); check("R2 addr", r, 32'hDEAD_BEEF);

        // Table walk: data decision matrix (R3 R4 R5 R6)
        for (int n = 0; n < 11; n++) begin
            logic [7:0] t;
            t = VEC[n];
            wr_reg(1'b0, (32'(t[7]) << 9) | (32'(t[6]) << 8) | (32'(t[5]) << 13));
            d_req = 1'b1; d_write = t[4]; d_hit = t[3];
            #1;
            check($sformatf("R3/R4/R5/R6 vec%0d alloc", n),  32'(d_alloc),   32'(t[2]));
            check($sformatf("R3/R4/R5/R6 vec%0d update", n), 32'(d_update),  32'(t[1]));
            check($sformatf("R3/R4/R5/R6 vec%0d hit", n),    32'(d_hit_out), 32'(t[0]));
            d_req = 1'b0;
        end

        // R11 no request means quiet outputs even when enabled and open
        wr_reg(1'b0, 32'h0000_2100);
        d_req = 1'b0; d_write = 1'b1; d_hit = 1'b1;
        #1;
        check("R11 idle", {29'b0, d_alloc, d_update, d_hit_out}, 32'h0);
        d_write = 1'b0; d_hit = 1'b0;

        // R6 disable and re-enable: hits visible again without refill
        d_req = 1'b1; d_hit = 1'b1;
        wr_reg(1'b0, 32'h0000_0000);
        #1; check("R6 off hit", 32'(d_hit_out), 32'h0);
        wr_reg(1'b0, 32'h0000_0100);
        #1; check("R6 re-enabled hit", 32'(d_hit_out), 32'h1);
        d_req = 1'b0; d_hit = 1'b0;

        // R10 burst output follows fill and burst enable
        wr_reg(1'b0, 32'h0000_0010);
        @(negedge clk); i_fill = 1'b1; i_fill_idx = 6'd1;
        #1; check("R10 burst on", 32'(i_burst), 32'h1);
        @(negedge clk); i_fill = 1'b0;
        #1; check("R10 burst idle", 32'(i_burst), 32'h0);
        wr_reg(1'b0, 32'h0000_0000);
        @(negedge clk); i_fill = 1'b1;
        #1; check("R10 burst off", 32'(i_burst), 32'h0);
        @(negedge clk); i_fill = 1'b0;

        // R9 fill sets valid bits
        fill_all();
        peek(0, v);  check("R9 fill 0", 32'(v), 32'h1);
        peek(37, v); check("R9 fill 37", 32'(v), 32'h1);
        peek(63, v); check("R9 fill 63", 32'(v), 32'h1);

        // R8 single entry clear; only bits [7:2] of the address word matter
        wr_reg(1'b1, 32'hABCD_FF14);             // index 5
        wr_reg(1'b0, 32'h0000_0004);
        peek(5, v); check("R8 entry5 cleared", 32'(v), 32'h0);
        peek(4, v); check("R8 entry4 kept", 32'(v), 32'h1);
        peek(6, v); check("R8 entry6 kept", 32'(v), 32'h1);
        rd_reg(1'b0, r); check("R8 cmd reads zero", r, 32'h0);

        // R8 clear regardless of freeze/enable/write-allocate written alongside
        wr_reg(1'b1, 32'h0000_0024);             // index 9
        wr_reg(1'b0, 32'h0000_2304);
        peek(9, v); check("R8 entry9 cleared frozen", 32'(v), 32'h0);
        rd_reg(1'b0, r); check("R8 ctrl after cmd", r, 32'h0000_2300);

        // R9 fill collides with single-entry clear on the same entry
        wr_reg(1'b1, 32'h0000_0080);             // index 32
        @(negedge clk);
        reg_we = 1'b1; reg_sel = 1'b0; reg_wdata = 32'h0000_0004;
        i_fill = 1'b1; i_fill_idx = 6'd32;
        @(negedge clk);
        reg_we = 1'b0; i_fill = 1'b0;
        peek(32, v); check("R9 clear wins one", 32'(v), 32'h0);
        peek(31, v); check("R9 neighbour kept", 32'(v), 32'h1);

        // R7 clear-all, with a colliding fill
        @(negedge clk);
        reg_we = 1'b1; reg_sel = 1'b0; reg_wdata = 32'h0000_0008;
        i_fill = 1'b1; i_fill_idx = 6'd20;
        @(negedge clk);
        reg_we = 1'b0; i_fill = 1'b0;
        peek(20, v); check("R7 clear wins all", 32'(v), 32'h0);
        peek(0, v);  check("R7 entry0", 32'(v), 32'h0);
        peek(63, v); check("R7 entry63", 32'(v), 32'h0);
        rd_reg(1'b0, r); check("R7 cmd reads zero", r, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule